// File: doc/BRIEF.md
# Banked Cartridge Memory Mapper

This block sits between a console's processor and video buses and the ROM and RAM arrays of a game cartridge. It turns each processor address into a program-ROM address or a work-RAM select. It turns each video-bus pattern address into a character-ROM address. The mapping is set by processor writes into a small register file.

Banks are loaded indirectly. An even-address write in the 0x8000–0x9FFF range chooses one of eight bank registers and sets two layout modes. The next odd-address write in that range stores a byte into the chosen register.

The program layout pins the last 8 KB bank in place, and a mode bit decides which lower window gets the second-to-last bank. The character layout mixes 2 KB and 1 KB windows, and a mode bit decides which half of pattern space holds which size. A separate even-address write in 0xA000–0xBFFF selects nametable mirroring.

All outputs are combinational from the current address and the registered state. The number of 8 KB program banks comes from a static input and must be a power of two, at least 2. All register writes take effect at the rising clock edge.

Top module: `cart_bank_mapper`

## Requirements
- R1: After reset all eight bank registers, the selected index and both mode bits are zero, and mirror_vert is 0 (horizontal).
- R2: For cpu_addr 0x6000–0x7FFF, ram_sel is 1, rom_sel is 0 and ram_addr equals cpu_addr − 0x6000. Below 0x6000 both ram_sel and rom_sel are 0, so reads there return zero. From 0x8000 up, rom_sel is 1.
- R3: A write to an even address in 0x8000–0x9FFF loads the index from data bits 2:0, the program mode from bit 6 and the character mode from bit 7.
- R4: A write to an odd address in 0x8000–0x9FFF stores the full data byte into the register named by the index. Indices 0–5 are character registers and indices 6–7 are program registers.
- R5: A write to an even address in 0xA000–0xBFFF sets mirror_vert to data bit 0 (1 = vertical). A write to an odd address there leaves mirror_vert unchanged.
- R6: prg_rom_addr is {bank, cpu_addr[12:0]}. Window 0xA000 uses program register 1 (index 7) and window 0xE000 uses bank count−1. In program mode 0, window 0x8000 uses program register 0 (index 6) and window 0xC000 uses bank count−2.
- R7: In program mode 1, window 0x8000 uses bank count−2 and window 0xC000 uses program register 0. Windows 0xA000 and 0xE000 are as in mode 0.
- R8: chr_rom_addr is {1 KB bank, vid_addr[9:0]}. In character mode 0, for vid_addr below 0x1000, bit 11 selects register 0 or 1; the register with bit 0 cleared, plus vid_addr bit 10, forms the 1 KB bank. From 0x1000 up, vid_addr[11:10] selects register 2–5 directly as the 1 KB bank.
- R9: In character mode 1 the halves swap. The 1 KB windows from registers 2–5 cover 0x0000–0x0FFF, and the 2 KB windows from registers 0–1 cover 0x1000–0x1FFF.
- R10: The program bank number is ANDed with count−1, so a register value beyond the ROM size wraps.
- R11: Writes with cpu_we low, and writes to 0x6000–0x7FFF or 0xC000–0xFFFF, change no mapping register or mirror_vert.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | Processor address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_we | input | 1 | Processor write strobe, sampled at the rising edge |
| vid_addr | input | 13 | Video-bus pattern address |
| prg_bank_count | input | PRG_BANK_W+1 | Number of 8 KB program banks (power of two, at least 2) |
| prg_rom_addr | output | PRG_BANK_W+13 | Program-ROM byte address |
| chr_rom_addr | output | CHR_BANK_W+10 | Character-ROM byte address |
| ram_sel | output | 1 | Work-RAM window selected |
| rom_sel | output | 1 | Program-ROM window selected |
| ram_addr | output | 13 | Work-RAM byte offset |
| mirror_vert | output | 1 | Mirroring: 0 horizontal, 1 vertical |

## Verification
Bank registers are loaded with distinct, recognisable values, so each output shows which register fed which window. The program windows are then probed in both program modes, with a wide and a narrow bank count. This separates a swapped window, a wrong fixed bank and a missing wrap mask. The character windows are probed at every 1 KB step in both character modes. This exposes a wrong 2 KB halving, a wrong register index or an unswapped half. Ignored writes are followed by probes of the state they could have disturbed, and a second reset checks the cleared state.

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper #(
  parameter int PRG_BANK_W = 6,
  parameter int CHR_BANK_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [15:0]             cpu_addr,
  input  logic [7:0]              cpu_wdata,
  input  logic                    cpu_we,
  input  logic [12:0]             vid_addr,
  input  logic [PRG_BANK_W:0]     prg_bank_count,
  output logic [PRG_BANK_W+12:0]  prg_rom_addr,
  output logic [CHR_BANK_W+9:0]   chr_rom_addr,
  output logic                    ram_sel,
  output logic                    rom_sel,
  output logic [12:0]             ram_addr,
  output logic                    mirror_vert
);
  localparam int NREGS = 8;

  logic [7:0] bank_q [NREGS];
  logic [2:0] idx_q;
  logic       prg_mode_q, chr_mode_q;

  logic       wr_sel, wr_mir, even;
  assign even   = ~cpu_addr[0];
  assign wr_sel = cpu_we && cpu_addr[15:13] == 3'b100;
  assign wr_mir = cpu_we && cpu_addr[15:13] == 3'b101 && even;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q       <= '0;
      prg_mode_q  <= 1'b0;
      chr_mode_q  <= 1'b0;
      mirror_vert <= 1'b0;
      for (int i = 0; i < NREGS; i++) bank_q[i] <= '0;
    end else begin
      if (wr_sel && even) begin
        idx_q      <= cpu_wdata[2:0];
        prg_mode_q <= cpu_wdata[6];
        chr_mode_q <= cpu_wdata[7];
      end
      if (wr_sel && !even) bank_q[idx_q] <= cpu_wdata;
      if (wr_mir) mirror_vert <= cpu_wdata[0];
    end
  end

  assign rom_sel  = cpu_addr[15];
  assign ram_sel  = cpu_addr[15:13] == 3'b011;
  assign ram_addr = cpu_addr[12:0];

  logic [PRG_BANK_W-1:0] prg_mask, prg_last, prg_penult, prg_raw;
  assign prg_mask   = PRG_BANK_W'(prg_bank_count - 1'b1);
  assign prg_last   = prg_mask;
  assign prg_penult = PRG_BANK_W'(prg_bank_count - 2'd2);

  always_comb begin
    case (cpu_addr[14:13])
      2'd0:    prg_raw = prg_mode_q ? prg_penult : PRG_BANK_W'(bank_q[6]);
      2'd1:    prg_raw = PRG_BANK_W'(bank_q[7]);
      2'd2:    prg_raw = prg_mode_q ? PRG_BANK_W'(bank_q[6]) : prg_penult;
      default: prg_raw = prg_last;
    endcase
  end

  assign prg_rom_addr = {prg_raw & prg_mask, cpu_addr[12:0]};

  logic       two_k;
  logic [7:0] reg_2k, reg_1k, chr_k;
  assign two_k  = vid_addr[12] == chr_mode_q;
  assign reg_2k = bank_q[{2'b00, vid_addr[11]}];
  assign reg_1k = bank_q[3'd2 + {1'b0, vid_addr[11:10]}];
  assign chr_k  = two_k ? {reg_2k[7:1], vid_addr[10]} : reg_1k;

  assign chr_rom_addr = {CHR_BANK_W'(chr_k), vid_addr[9:0]};
endmodule

module cart_bank_mapper_chk #(
  parameter int PRG_BANK_W = 6
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [15:0]            cpu_addr,
  input logic                   cpu_we,
  input logic                   wr_bit,
  input logic [9:0]             vid_low,
  input logic [PRG_BANK_W:0]    prg_bank_count,
  input logic [PRG_BANK_W+12:0] prg_rom_addr,
  input logic [9:0]             chr_low,
  input logic                   ram_sel,
  input logic                   rom_sel,
  input logic [12:0]            ram_addr,
  input logic                   mirror_vert
);
  logic mir_wr;
  assign mir_wr = cpu_we && cpu_addr[15:13] == 3'b101 && !cpu_addr[0];

  // R5
  mirror_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mir_wr |=> mirror_vert == $past(wr_bit));

  // R11
  mirror_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mir_wr |=> $stable(mirror_vert));

  // R2
  ram_rom_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_sel |-> !rom_sel && ram_addr == 13'(cpu_addr - 16'h6000));

  // R6
  last_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_addr[15:13] == 3'b111 |->
      prg_rom_addr[PRG_BANK_W+12:13] == PRG_BANK_W'(prg_bank_count - 1'b1));

  // R6
  prg_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rom_sel |-> prg_rom_addr[12:0] == cpu_addr[12:0]);

  // R8
  chr_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chr_low == vid_low);
endmodule

bind cart_bank_mapper cart_bank_mapper_chk #(.PRG_BANK_W(PRG_BANK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_we(cpu_we),
  .wr_bit(cpu_wdata[0]), .vid_low(vid_addr[9:0]),
  .prg_bank_count(prg_bank_count), .prg_rom_addr(prg_rom_addr),
  .chr_low(chr_rom_addr[9:0]), .ram_sel(ram_sel), .rom_sel(rom_sel),
  .ram_addr(ram_addr), .mirror_vert(mirror_vert)
);

// File: tb/cart_bank_mapper_bench.sv
module cart_bank_mapper_bench;
  localparam int PW = 6;
  localparam int CW = 8;

  logic            clk = 0, rst_n = 0;
  logic [15:0]     cpu_addr = 0;
  logic [7:0]      cpu_wdata = 0;
  logic            cpu_we = 0;
  logic [12:0]     vid_addr = 0;
  logic [PW:0]     prg_bank_count = 7'd16;
  logic [PW+12:0]  prg_rom_addr;
  logic [CW+9:0]   chr_rom_addr;
  logic            ram_sel, rom_sel, mirror_vert;
  logic [12:0]     ram_addr;

  cart_bank_mapper #(.PRG_BANK_W(PW), .CHR_BANK_W(CW)) u_cart_bank_mapper (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_we(cpu_we), .vid_addr(vid_addr), .prg_bank_count(prg_bank_count),
    .prg_rom_addr(prg_rom_addr), .chr_rom_addr(chr_rom_addr),
    .ram_sel(ram_sel), .rom_sel(rom_sel), .ram_addr(ram_addr),
    .mirror_vert(mirror_vert));

  always #4 clk = ~clk;

  int nchk = 0, nfail = 0;
  bit done = 0;

  typedef struct packed {
    logic [1:0]  kind;
    logic [3:0]  req;
    logic [15:0] a;
    logic [7:0]  d;
  } vec_t;

  localparam logic [1:0] K_WR = 2'd0, K_PRG = 2'd1, K_CHR = 2'd2;
  localparam int N = 55;
  localparam vec_t VECS [N] = '{
    // R3 R4: load registers 6,7 (prg) and 0..5 (chr), modes 0
    '{K_WR,4'd4,16'h8000,8'h06}, '{K_WR,4'd4,16'h8001,8'h05},
    '{K_WR,4'd4,16'h8000,8'h07}, '{K_WR,4'd4,16'h8001,8'h09},
    '{K_WR,4'd4,16'h8000,8'h00}, '{K_WR,4'd4,16'h8001,8'h20},
    '{K_WR,4'd4,16'h8000,8'h01}, '{K_WR,4'd4,16'h9FFF,8'h31},
    '{K_WR,4'd4,16'h9FFE,8'h02}, '{K_WR,4'd4,16'h8001,8'h40},
    '{K_WR,4'd4,16'h8000,8'h03}, '{K_WR,4'd4,16'h8001,8'h41},
    '{K_WR,4'd4,16'h8000,8'h04}, '{K_WR,4'd4,16'h8001,8'h42},
    '{K_WR,4'd4,16'h8000,8'h05}, '{K_WR,4'd4,16'h8001,8'h43},
    // R6: program mode 0, count 16
    '{K_PRG,4'd6,16'h8123,8'h05}, '{K_PRG,4'd6,16'hA456,8'h09},
    '{K_PRG,4'd6,16'hC789,8'h0E}, '{K_PRG,4'd6,16'hE000,8'h0F},
    '{K_PRG,4'd6,16'hFFFF,8'h0F},
    // R8: character mode 0
    '{K_CHR,4'd8,16'h0000,8'h20}, '{K_CHR,4'd8,16'h0400,8'h21},
    '{K_CHR,4'd8,16'h0800,8'h30}, '{K_CHR,4'd8,16'h0C05,8'h31},
    '{K_CHR,4'd8,16'h1000,8'h40}, '{K_CHR,4'd8,16'h1400,8'h41},
    '{K_CHR,4'd8,16'h1800,8'h42}, '{K_CHR,4'd8,16'h1FFF,8'h43},
    // R3: both modes to 1
    '{K_WR,4'd3,16'h8000,8'hC0},
    // R7: program mode 1
    '{K_PRG,4'd7,16'h8000,8'h0E}, '{K_PRG,4'd7,16'hA000,8'h09},
    '{K_PRG,4'd7,16'hC000,8'h05}, '{K_PRG,4'd7,16'hE000,8'h0F},
    // R9: character mode 1
    '{K_CHR,4'd9,16'h0000,8'h40}, '{K_CHR,4'd9,16'h0400,8'h41},
    '{K_CHR,4'd9,16'h0800,8'h42}, '{K_CHR,4'd9,16'h0C00,8'h43},
    '{K_CHR,4'd9,16'h1000,8'h20}, '{K_CHR,4'd9,16'h1400,8'h21},
    '{K_CHR,4'd9,16'h1800,8'h30}, '{K_CHR,4'd9,16'h1C00,8'h31},
    // R10: oversized program banks wrap
    '{K_WR,4'd10,16'h8000,8'hC6}, '{K_WR,4'd10,16'h8001,8'h25},
    '{K_WR,4'd10,16'h8000,8'hC7}, '{K_WR,4'd10,16'h8001,8'hFA},
    '{K_PRG,4'd10,16'hC000,8'h05}, '{K_PRG,4'd10,16'hA000,8'h0A},
    // R11: writes outside the register ranges
    '{K_WR,4'd11,16'hC000,8'hFF}, '{K_WR,4'd11,16'hE001,8'hFF},
    '{K_WR,4'd11,16'h6000,8'hFF}, '{K_WR,4'd11,16'hA001,8'h01},
    '{K_PRG,4'd11,16'hA000,8'h0A}, '{K_PRG,4'd11,16'h8000,8'h0E},
    '{K_CHR,4'd11,16'h0000,8'h40}
  };

  task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic we = 1'b1);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_we = we;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic prg_probe(input int req, input logic [15:0] a, input logic [7:0] bank);
    @(negedge clk);
    cpu_addr = a;
    #2;
    chk(req, 32'(prg_rom_addr), 32'({bank[PW-1:0], a[12:0]}));
  endtask

  task automatic chr_probe(input int req, input logic [15:0] a, input logic [7:0] bank);
    @(negedge clk);
    vid_addr = a[12:0];
    #2;
    chk(req, 32'(chr_rom_addr), 32'({bank, a[9:0]}));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    prg_probe(1, 16'h8000, 8'h00);
    prg_probe(1, 16'hC000, 8'h0E);
    chr_probe(1, 16'h1C00, 8'h00);
    chk(1, 32'(mirror_vert), 32'd0);

    for (int i = 0; i < N; i++) begin
      vec_t v;
      v = VECS[i];
      case (v.kind)
        K_WR:    wr(v.a, v.d);
        K_PRG:   prg_probe(int'(v.req), v.a, v.d);
        default: chr_probe(int'(v.req), v.a, v.d);
      endcase
    end

    // R11: odd mirror write (from table) left horizontal
    chk(11, 32'(mirror_vert), 32'd0);
    // R5: even writes set mirroring, odd ignored
    wr(16'hA000, 8'h01);
    chk(5, 32'(mirror_vert), 32'd1);
    wr(16'hA001, 8'h00);
    chk(5, 32'(mirror_vert), 32'd1);
    wr(16'hBFFE, 8'h02);
    chk(5, 32'(mirror_vert), 32'd0);

    // R11: strobe low does not write (index is 7)
    wr(16'h8001, 8'h77, 1'b0);
    prg_probe(11, 16'hA000, 8'h0A);

    // R2: RAM and ROM window decode
    @(negedge clk); cpu_addr = 16'h6000; #2;
    chk(2, 32'({ram_sel, rom_sel, ram_addr}), 32'({1'b1, 1'b0, 13'h0000}));
    @(negedge clk); cpu_addr = 16'h7FFF; #2;
    chk(2, 32'({ram_sel, rom_sel, ram_addr}), 32'({1'b1, 1'b0, 13'h1FFF}));
    @(negedge clk); cpu_addr = 16'h5FFF; #2;
    chk(2, 32'({ram_sel, rom_sel}), 32'd0);
    @(negedge clk); cpu_addr = 16'h8000; #2;
    chk(2, 32'({ram_sel, rom_sel}), 32'd1);

    // R10: narrower ROM (8 banks), program mode 1
    prg_bank_count = 7'd8;
    prg_probe(10, 16'hE000, 8'h07);
    prg_probe(10, 16'h8000, 8'h06);
    prg_probe(10, 16'hA000, 8'h02);
    prg_probe(10, 16'hC000, 8'h05);

    // R1: second reset clears registers and modes
    prg_bank_count = 7'd16;
    wr(16'hA000, 8'h01);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    chk(1, 32'(mirror_vert), 32'd0);
    prg_probe(1, 16'hA000, 8'h00);
    prg_probe(1, 16'h8000, 8'h00);
    chr_probe(1, 16'h0400, 8'h01);

    finish_run();
  end
endmodule